// File: doc/BRIEF.md
# Segmented Address Generation Unit

This unit turns a 32-bit offset into a 32-bit linear address. It holds six segment registers. Each register keeps a 16-bit selector, a 32-bit base and a 32-bit limit. Every access request carries an offset, an access size and an access kind: code fetch, stack operation, frame-pointer-relative data or general data. A request may also carry a segment-override code. The unit picks a segment from the kind and the override, adds that segment's base to the offset, and checks the last byte touched against the segment limit. The result appears one cycle after the request.

A load port writes a selector, a base and a limit into one register in a single cycle. The base and limit come in already resolved; no table lookup happens here. After reset every base is zero and every limit covers the full 4 GB space. This gives a flat memory model, in which the linear address equals the offset.

The segment registers are indexed 0 to 5. Index 0 is extra segment E, 1 is code, 2 is stack, 3 is primary data, 4 is extra segment F and 5 is extra segment G. The access kinds are encoded 0 for code fetch, 1 for stack operation, 2 for frame-relative data and 3 for general data.

Top module: `seg_agu`

## Requirements
- R1: After reset, `out_valid` is 0. Every selector and base is 0 and every limit is 0xFFFFFFFF, so a request returns its offset as the address and raises no fault.
- R2: A request presented on `req_valid` produces `out_valid` on the next cycle, with `lin_addr` = segment base + offset modulo 2^32. A cycle with no request produces no `out_valid`.
- R3: Kind 0 (code fetch) always uses segment index 1, whatever the override inputs are.
- R4: Kind 1 (stack operation) always uses segment index 2, whatever the override inputs are.
- R5: Kind 2 (frame-relative data) uses index 2 by default. A valid override code 0 to 5 selects that index instead.
- R6: Kind 3 (general data) uses index 3 by default. A valid override code 0 to 5 selects that index instead.
- R7: An override code of 6 or 7 is ignored, and the default segment of the kind is used.
- R8: A load writes the selector, base and limit of the register named by `ld_idx`. A load with `ld_idx` of 6 or 7 changes no register.
- R9: A request issued in the same cycle as a load sees the register's old contents. A request issued on the next cycle sees the new contents.
- R10: `limit_fault` is 1 when offset + (`req_size`+1) − 1 is greater than the limit. This sum is computed without wrapping, and `req_size` encodes 1 to 4 bytes. The address is still produced when the fault is raised.
- R11: `seg_idx` and `seg_sel` report the index and the selector of the segment used by the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Segment load strobe |
| ld_idx | input | 3 | Register index to load (0 to 5) |
| ld_sel | input | 16 | Selector to store |
| ld_base | input | 32 | Base to store |
| ld_limit | input | 32 | Limit to store |
| req_valid | input | 1 | Address request strobe |
| req_kind | input | 2 | Access kind: 0 code, 1 stack, 2 frame-relative, 3 data |
| req_ovr_valid | input | 1 | Override code present |
| req_ovr_idx | input | 3 | Override segment index |
| req_offset | input | 32 | Offset within the segment |
| req_size | input | 2 | Access size minus one, in bytes |
| out_valid | output | 1 | Result valid |
| lin_addr | output | 32 | Linear address |
| limit_fault | output | 1 | Last byte lies beyond the limit |
| seg_idx | output | 3 | Index of the segment used |
| seg_sel | output | 16 | Selector of the segment used |

## Verification
The assertions check properties that hold on every cycle and depend only on the ports:
- the one-cycle link between `req_valid` and `out_valid`;
- the forced code and stack indices;
- the fallback to index 3 when the override code is out of range;
- that a zero-offset, one-byte access never faults;
- that a reported index stays within 0 to 5.

Other behaviour can only be shown by the bench's scenarios, because it depends on the register contents. This covers the address sums, the wrap of the address and the limit compare at its boundary. It also covers a load taking effect on the following cycle, and a load to index 6 or 7 being ignored.

// File: rtl/seg_agu_pkg.sv
package seg_agu_pkg;
    localparam int SEG_N  = 6;
    localparam int IDX_W  = 3;
    localparam int SEL_W  = 16;
    localparam int ADDR_W = 32;
    localparam int SIZE_W = 2;

    typedef enum logic [IDX_W-1:0] {
        SEG_XE = 3'd0,
        SEG_CODE = 3'd1,
        SEG_STK = 3'd2,
        SEG_DAT = 3'd3,
        SEG_XF = 3'd4,
        SEG_XG = 3'd5
    } seg_idx_e;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_STACK = 2'd1,
        ACC_FRAME = 2'd2,
        ACC_DATA  = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] limit;
    } seg_entry_t;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
    import seg_agu_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ld_valid,
    input  logic [IDX_W-1:0]       ld_idx,
    input  seg_entry_t             ld_entry,
    output seg_entry_t             tbl [SEG_N]
);
    localparam seg_entry_t FLAT = '{sel: '0, base: '0, limit: '1};

    for (genvar g = 0; g < SEG_N; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tbl[g] <= FLAT;
            end else if (ld_valid && (ld_idx == IDX_W'(g))) begin
                tbl[g] <= ld_entry;
            end
        end
    end
endmodule

// File: rtl/seg_select.sv
module seg_select
    import seg_agu_pkg::*;
(
    input  logic [1:0]       kind,
    input  logic             ovr_valid,
    input  logic [IDX_W-1:0] ovr_idx,
    output logic [IDX_W-1:0] idx
);
    logic ovr_ok;
    assign ovr_ok = ovr_valid && (ovr_idx < IDX_W'(SEG_N));

    always_comb begin
        unique case (acc_kind_e'(kind))
            ACC_FETCH: idx = SEG_CODE;
            ACC_STACK: idx = SEG_STK;
            ACC_FRAME: idx = ovr_ok ? ovr_idx : SEG_STK;
            ACC_DATA:  idx = ovr_ok ? ovr_idx : SEG_DAT;
            default:   idx = SEG_DAT;
        endcase
    end
endmodule

// File: rtl/seg_addr_calc.sv
module seg_addr_calc
    import seg_agu_pkg::*;
(
    input  seg_entry_t        entry,
    input  logic [ADDR_W-1:0] offset,
    input  logic [SIZE_W-1:0] size_m1,
    output logic [ADDR_W-1:0] addr,
    output logic              fault
);
    localparam int EXT_W = ADDR_W + 1;
    logic [EXT_W-1:0] last_byte;

    assign addr      = entry.base + offset;
    assign last_byte = {1'b0, offset} + EXT_W'(size_m1);
    assign fault     = last_byte > {1'b0, entry.limit};
endmodule

// File: rtl/seg_agu.sv
module seg_agu
    import seg_agu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ld_valid,
    input  logic [2:0]  ld_idx,
    input  logic [15:0] ld_sel,
    input  logic [31:0] ld_base,
    input  logic [31:0] ld_limit,
    input  logic        req_valid,
    input  logic [1:0]  req_kind,
    input  logic        req_ovr_valid,
    input  logic [2:0]  req_ovr_idx,
    input  logic [31:0] req_offset,
    input  logic [1:0]  req_size,
    output logic        out_valid,
    output logic [31:0] lin_addr,
    output logic        limit_fault,
    output logic [2:0]  seg_idx,
    output logic [15:0] seg_sel
);
    seg_entry_t        tbl [SEG_N];
    seg_entry_t        ld_entry;
    seg_entry_t        cur;
    logic [IDX_W-1:0]  idx_c;
    logic [ADDR_W-1:0] addr_c;
    logic              fault_c;

    assign ld_entry = '{sel: ld_sel, base: ld_base, limit: ld_limit};

    seg_regfile u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_valid (ld_valid),
        .ld_idx   (ld_idx),
        .ld_entry (ld_entry),
        .tbl      (tbl)
    );

    seg_select u_sel (
        .kind      (req_kind),
        .ovr_valid (req_ovr_valid),
        .ovr_idx   (req_ovr_idx),
        .idx       (idx_c)
    );

    always_comb begin
        cur = tbl[0];
        for (int i = 1; i < SEG_N; i++) begin
            if (idx_c == IDX_W'(i)) cur = tbl[i];
        end
    end

    seg_addr_calc u_calc (
        .entry   (cur),
        .offset  (req_offset),
        .size_m1 (req_size),
        .addr    (addr_c),
        .fault   (fault_c)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            lin_addr    <= '0;
            limit_fault <= 1'b0;
            seg_idx     <= '0;
            seg_sel     <= '0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                lin_addr    <= addr_c;
                limit_fault <= fault_c;
                seg_idx     <= idx_c;
                seg_sel     <= cur.sel;
            end
        end
    end
endmodule

// File: rtl/seg_agu_chk.sv
module seg_agu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [1:0]  req_kind,
    input logic        req_ovr_valid,
    input logic [2:0]  req_ovr_idx,
    input logic [31:0] req_offset,
    input logic [1:0]  req_size,
    input logic        out_valid,
    input logic        limit_fault,
    input logic [2:0]  seg_idx
);
    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);
    // R2
    idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);
    // R3
    code_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd0) |=> (seg_idx == 3'd1));
    // R4
    stack_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd1) |=> (seg_idx == 3'd2));
    // R7
    bad_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd3 && req_ovr_valid && req_ovr_idx > 3'd5)
        |=> (seg_idx == 3'd3));
    // R10
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_offset == 32'd0 && req_size == 2'd0) |=> !limit_fault);
    // R11
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (seg_idx <= 3'd5));
endmodule

bind seg_agu seg_agu_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_kind      (req_kind),
    .req_ovr_valid (req_ovr_valid),
    .req_ovr_idx   (req_ovr_idx),
    .req_offset    (req_offset),
    .req_size      (req_size),
    .out_valid     (out_valid),
    .limit_fault   (limit_fault),
    .seg_idx       (seg_idx)
);

// File: tb/seg_agu_tb_top.sv
module seg_agu_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic [2:0]  ld_idx = '0;
    logic [15:0] ld_sel = '0;
    logic [31:0] ld_base = '0;
    logic [31:0] ld_limit = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic        req_ovr_valid = 1'b0;
    logic [2:0]  req_ovr_idx = '0;
    logic [31:0] req_offset = '0;
    logic [1:0]  req_size = '0;
    logic        out_valid;
    logic [31:0] lin_addr;
    logic        limit_fault;
    logic [2:0]  seg_idx;
    logic [15:0] seg_sel;

    int checks = 0;
    int errors = 0;
    logic [15:0] m_sel [6];
    logic [31:0] m_base [6];
    logic [31:0] m_lim [6];

    always #2.5 clk = ~clk;

    seg_agu dut_i (.*);

    function automatic logic [2:0] exp_idx(logic [1:0] k, logic ov, logic [2:0] oi);
        logic ok = ov && (oi < 3'd6);
        case (k)
            2'd0: return 3'd1;
            2'd1: return 3'd2;
            2'd2: return ok ? oi : 3'd2;
            default: return ok ? oi : 3'd3;
        endcase
    endfunction

    function automatic logic exp_fault(logic [31:0] off, logic [1:0] sz, logic [31:0] lim);
        return ({1'b0, off} + 33'(sz)) > {1'b0, lim};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic lv, input logic [2:0] li, input logic [15:0] ls,
                        input logic [31:0] lb, input logic [31:0] ll,
                        input logic rv, input logic [1:0] k, input logic ov,
                        input logic [2:0] oi, input logic [31:0] off,
                        input logic [1:0] sz, input string tag);
        logic [2:0]  ei;
        logic [31:0] ea;
        logic        ef;
        logic [15:0] es;
        ld_valid = lv; ld_idx = li; ld_sel = ls; ld_base = lb; ld_limit = ll;
        req_valid = rv; req_kind = k; req_ovr_valid = ov; req_ovr_idx = oi;
        req_offset = off; req_size = sz;
        ei = exp_idx(k, ov, oi);
        ea = m_base[ei] + off;
        ef = exp_fault(off, sz, m_lim[ei]);
        es = m_sel[ei];
        if (lv && li < 3'd6) begin
            m_sel[li] = ls; m_base[li] = lb; m_lim[li] = ll;
        end
        @(negedge clk);
        check(out_valid == rv, {tag, " R2 valid"}, 64'(out_valid), 64'(rv));
        if (rv) begin
            check(lin_addr == ea, {tag, " R2 addr"}, 64'(lin_addr), 64'(ea));
            check(limit_fault == ef, {tag, " R10 fault"}, 64'(limit_fault), 64'(ef));
            check(seg_idx == ei, {tag, " R11 idx"}, 64'(seg_idx), 64'(ei));
            check(seg_sel == es, {tag, " R11 sel"}, 64'(seg_sel), 64'(es));
        end
    endtask

    task automatic req(input logic [1:0] k, input logic ov, input logic [2:0] oi,
                       input logic [31:0] off, input logic [1:0] sz, input string tag);
        step(1'b0, 3'd0, 16'd0, 32'd0, 32'd0, 1'b1, k, ov, oi, off, sz, tag);
    endtask

    task automatic load(input logic [2:0] li, input logic [15:0] ls,
                        input logic [31:0] lb, input logic [31:0] ll, input string tag);
        step(1'b1, li, ls, lb, ll, 1'b0, 2'd0, 1'b0, 3'd0, 32'd0, 2'd0, tag);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 6; i++) begin
            m_sel[i] = '0; m_base[i] = '0; m_lim[i] = '1;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(out_valid == 1'b0, "R1 reset valid", 64'(out_valid), 64'd0);
        // R1 flat model after reset
        req(2'd3, 1'b0, 3'd0, 32'hFFFF_FFFC, 2'd3, "R1 flat");
        req(2'd0, 1'b0, 3'd0, 32'h1234_5678, 2'd0, "R1 flat code");
        step(1'b0, 3'd0, 16'd0, 32'd0, 32'd0, 1'b0, 2'd0, 1'b0, 3'd0, 32'd0, 2'd0, "R2 idle");
        // R8 load every register
        for (int i = 0; i < 6; i++)
            load(3'(i), 16'h100 + 16'(i), 32'h1000_0000 * (i + 1), 32'h0000_0FFF + 32'(i), "R8 load");
        // R8 ignored index
        load(3'd6, 16'hDEAD, 32'hDEAD_0000, 32'd0, "R8 bad idx");
        load(3'd7, 16'hBEEF, 32'hBEEF_0000, 32'd0, "R8 bad idx");
        for (int i = 0; i < 6; i++) req(2'd3, 1'b1, 3'(i), 32'h10, 2'd1, "R8 R6 readback");
        // R3 R4 ignore overrides
        req(2'd0, 1'b1, 3'd4, 32'h20, 2'd0, "R3 code");
        req(2'd1, 1'b1, 3'd5, 32'h20, 2'd0, "R4 stack");
        // R5 frame default and override
        req(2'd2, 1'b0, 3'd0, 32'h40, 2'd3, "R5 frame");
        req(2'd2, 1'b1, 3'd0, 32'h40, 2'd3, "R5 frame ovr");
        // R7 bad override codes
        req(2'd3, 1'b1, 3'd6, 32'h8, 2'd0, "R7 data ovr6");
        req(2'd2, 1'b1, 3'd7, 32'h8, 2'd0, "R7 frame ovr7");
        // R10 boundary on data segment limit 0xFFF+3
        req(2'd3, 1'b0, 3'd0, 32'h0000_1002, 2'd0, "R10 last byte in");
        req(2'd3, 1'b0, 3'd0, 32'h0000_1002, 2'd1, "R10 one over");
        req(2'd3, 1'b0, 3'd0, 32'h0000_0FFF, 2'd3, "R10 four in");
        // R9 load in same cycle as a code request
        step(1'b1, 3'd1, 16'h0777, 32'h0ABC_0000, 32'hFFFF_FFFF, 1'b1, 2'd0, 1'b0, 3'd0,
             32'h5, 2'd0, "R9 same cycle");
        req(2'd0, 1'b0, 3'd0, 32'h5, 2'd0, "R9 next cycle");
        // R10 wrap: full limit, top offsets
        load(3'd3, 16'h1, 32'hF000_0000, 32'hFFFF_FFFF, "R10 setup");
        req(2'd3, 1'b0, 3'd0, 32'hFFFF_FFFF, 2'd0, "R10 R2 wrap ok");
        req(2'd3, 1'b0, 3'd0, 32'hFFFF_FFFF, 2'd1, "R10 wrap fault");
        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] lim = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : ($urandom % 32'h10000);
            logic [31:0] off = ($urandom % 2 == 0) ? $urandom : lim - 32'($urandom % 6) + 32'd2;
            step(($urandom % 5) == 0, 3'($urandom), 16'($urandom), $urandom, lim,
                 ($urandom % 4) != 0, 2'($urandom), 1'($urandom), 3'($urandom),
                 off, 2'($urandom), "R2 R5 R6 R10 random");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule